// File: doc/BRIEF.md
# Conversion Sequencer with Data-Ready Flags

This block decides when a touch-controller measurement set begins and ends. A command selects one of sixteen function codes, a precision bit and whether sensing is on. A configuration write sets host mode, precision and the sense switch. Once sensing is on and the sequencer is idle, the block starts the selected function. Some functions wait for the pen to be down. A pending result either holds sensing off or lets it run on, depending on the function and on host mode. A programmable cycle count stands in for the conversion time. When that count runs out, a function-specific mask is merged into a 16-bit data-ready register.

Reads of the result registers, reported to the block as notifications, clear the matching data-ready bits. A status read returns the data-ready bits together with a reset-seen flag and a converter-state flag. It then clears the three self-test bits. A single interrupt pin, registered, can show pen-up, "no data ready" or "pen-up with data ready", as picked by a 2-bit pin mode. A soft-reset command returns the sequencer to its power-up state. The block performs no arithmetic on samples.

Top module: `conv_seq`

## Requirements
- R1: After reset `busy`, `act_valid`, `sense_en`, `irq` and `dav` are all 0, and `status_word` reads 0x0004 (status flag 1 at bit 2, reset-seen flag 0 at bit 7).
- R2: In a cycle with no command, configuration, pin-mode or read event, a start occurs when sensing is on, the block is idle and the function's gate allows it. `busy` rises at the next edge, and at that edge `act_func`/`act_prec` take the pending function and precision.
- R3: A conversion holds `busy` for `conv_len`+1 cycles. At its end `busy` and `act_valid` fall, and the function's mask is ORed into `dav`. The masks by code are: 0→0xF000, 1→0xC000, 2→0x8000, 3→0x4000, 4→0x3000, 5→0x0800, 6→0x0400, 7→0x0200, 8→0x0800, 9→0x0040, 10→0x0020, 11→0x0080.
- R4: Codes 0–4 start only while `pen_down` is 1. Codes 5–11 start with the pen up.
- R5: With any `dav` bit set, evaluation turns sensing off under three conditions: for codes 5–7 and 9–11 always; for codes 2–4 only while the pen is down; for codes 0–1 only when host mode is off. Code 8 is never turned off this way, and it restarts after each completion.
- R6: Codes 12–15 never start a conversion.
- R7: A read notification clears data-ready bits by address: 0→0x8000, 1→0x4000, 2→0x2000, 3→0x1000, 4→0x0800, 5→0x0400, 6→0x2200, 7→0x00E0. Other addresses clear nothing.
- R8: `status_word` = `dav` OR (reset-seen << 7) OR (status flag << 2). A read at address 7 sets reset-seen. Each read latches `rd_pnd`. A start sets the status flag to the inverse of the latched `rd_pnd`.
- R9: A command or configuration write that turns sensing off while busy drops `busy` at the next edge, and no mask is posted.
- R10: `irq` is registered one cycle behind its inputs. Pin mode 0 gives pen-up AND data-ready. Mode 2 gives pen-up. Modes 1 and 3 give "no data ready".
- R11: A command with `cmd_soft_rst` set restores the R1 state. It also clears the pending function, the precision and the pin mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pen_down | input | 1 | Pen contact level |
| cmd_valid | input | 1 | Command event strobe |
| cmd_soft_rst | input | 1 | Command is a soft reset |
| cmd_func | input | 4 | Function code to select |
| cmd_prec | input | 1 | Precision to select |
| cmd_sense_off | input | 1 | 1 turns sensing off |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_host | input | 1 | Host-mode bit |
| cfg_sense_off | input | 1 | 1 turns sensing off |
| cfg_prec | input | 1 | Precision to select |
| pin_wr | input | 1 | Pin-mode write strobe |
| pin_sel | input | 2 | New interrupt pin mode |
| conv_len | input | CNT_W | Conversion length minus one, in cycles |
| rd_valid | input | 1 | Register read notification |
| rd_addr | input | 4 | Address of the read |
| rd_pnd | input | 1 | Converter-state bit carried by the read |
| busy | output | 1 | Conversion in progress |
| act_valid | output | 1 | A function is active |
| act_func | output | 4 | Active function code |
| act_prec | output | 1 | Precision latched at start |
| dav | output | 16 | Data-ready mask |
| status_word | output | 16 | Value a status read returns |
| sense_en | output | 1 | Sensing enabled |
| irq | output | 1 | Interrupt pin |

## Verification
The bench builds the block with `CNT_W` = 4 and a registered interrupt pin. With this width both ends of the conversion-length range can be driven: a one-cycle conversion at `conv_len` = 0 and a sixteen-cycle one at 15. Each of these can then be timed edge for edge. It also keeps the runs short enough that every function code, each pen and host-mode gate, and a cancellation in mid-count are all covered in one pass.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int DAV_W   = 16;
   localparam int FUNC_W  = 4;

   // start-gating class of a function code
   localparam logic [2:0] GC_SCAN = 3'd0;  // codes 0,1: pen gate, host-mode sensitive
   localparam logic [2:0] GC_PEN  = 3'd1;  // codes 2..4: pen gate
   localparam logic [2:0] GC_ONCE = 3'd2;  // one-shot, no pen gate
   localparam logic [2:0] GC_LOOP = 3'd3;  // auxiliary scan, free running
   localparam logic [2:0] GC_NONE = 3'd4;  // reserved codes

   function automatic logic [2:0] fn_class(input logic [FUNC_W-1:0] f);
      unique case (f)
         4'd0, 4'd1:                         return GC_SCAN;
         4'd2, 4'd3, 4'd4:                   return GC_PEN;
         4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11: return GC_ONCE;
         4'd8:                               return GC_LOOP;
         default:                            return GC_NONE;
      endcase
   endfunction

   function automatic logic [DAV_W-1:0] fn_post(input logic [FUNC_W-1:0] f);
      unique case (f)
         4'd0:  return 16'hF000;
         4'd1:  return 16'hC000;
         4'd2:  return 16'h8000;
         4'd3:  return 16'h4000;
         4'd4:  return 16'h3000;
         4'd5:  return 16'h0800;
         4'd6:  return 16'h0400;
         4'd7:  return 16'h0200;
         4'd8:  return 16'h0800;
         4'd9:  return 16'h0040;
         4'd10: return 16'h0020;
         4'd11: return 16'h0080;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [DAV_W-1:0] rd_clear(input logic [3:0] a);
      unique case (a)
         4'd0: return 16'h8000;
         4'd1: return 16'h4000;
         4'd2: return 16'h2000;
         4'd3: return 16'h1000;
         4'd4: return 16'h0800;
         4'd5: return 16'h0400;
         4'd6: return 16'h2200;
         4'd7: return 16'h00E0;
         default: return 16'h0000;
      endcase
   endfunction
endpackage

// File: rtl/seq_masks.sv
module seq_masks
   import seq_pkg::*;
(
   input  logic [FUNC_W-1:0] act_fn,
   input  logic              rd_valid,
   input  logic [3:0]        rd_addr,
   output logic [DAV_W-1:0]  set_mask,
   output logic [DAV_W-1:0]  clr_mask
);
   always_comb begin
      set_mask = fn_post(act_fn);
      clr_mask = rd_valid ? rd_clear(rd_addr) : '0;
   end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cancel,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (cancel) begin
         busy  <= 1'b0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= len;
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = busy && (cnt_q == '0);

   // R3: a running count that has not reached zero keeps the block busy
   p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q != '0 && !cancel) |=> busy);

   // R3: the count only moves downward while running
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cancel && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seq_pin.sv
module seq_pin #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       pen,
   input  logic       dav_any,
   output logic       irq
);
   logic pin_val;

   always_comb begin
      unique case (mode)
         2'd0:    pin_val = !pen && dav_any;
         2'd2:    pin_val = !pen;
         default: pin_val = !dav_any;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pin_val;
         end
         assign irq = irq_q;

         // R10: pen-only mode with the pen down holds the pin low next cycle
         p_pen_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 2'd2 && pen) |=> !irq);
         // R10: data-ready modes with nothing pending raise the pin next cycle
         p_nodata_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode == 2'd1 || mode == 2'd3) && !dav_any) |=> irq);
      end else begin : g_comb
         assign irq = pin_val;
      end
   endgenerate
endmodule

// File: rtl/conv_seq.sv
module conv_seq
   import seq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pen_down,
   input  logic             cmd_valid,
   input  logic             cmd_soft_rst,
   input  logic [3:0]       cmd_func,
   input  logic             cmd_prec,
   input  logic             cmd_sense_off,
   input  logic             cfg_wr,
   input  logic             cfg_host,
   input  logic             cfg_sense_off,
   input  logic             cfg_prec,
   input  logic             pin_wr,
   input  logic [1:0]       pin_sel,
   input  logic [CNT_W-1:0] conv_len,
   input  logic             rd_valid,
   input  logic [3:0]       rd_addr,
   input  logic             rd_pnd,
   output logic             busy,
   output logic             act_valid,
   output logic [3:0]       act_func,
   output logic             act_prec,
   output logic [15:0]      dav,
   output logic [15:0]      status_word,
   output logic             sense_en,
   output logic             irq
);
   localparam int STAT_BIT_RST = 7;
   localparam int STAT_BIT_PND = 2;

   generate
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("conv_seq: CNT_W must lie in 1..24");
      end
      if (DAV_W != 16 || FUNC_W != 4) begin : g_bad_pkg
         $error("conv_seq: package widths do not match the port widths");
      end
   endgenerate

   logic              sense_q, host_q, nprec_q, aprec_q, avalid_q;
   logic              rstflag_q, stflag_q, pnd_q;
   logic [FUNC_W-1:0] nfunc_q, afunc_q;
   logic [1:0]        pin_mode_q;
   logic [DAV_W-1:0]  dav_q, dav_d, set_mask, clr_mask;

   logic soft_rst, any_ev, off_req, cancel, start, eval_dis;
   logic gate_ok, dis_cond, dav_any, tmr_busy, tmr_done, cmp_done;
   logic [2:0] cls;

   assign soft_rst = cmd_valid && cmd_soft_rst;
   assign any_ev   = cmd_valid || cfg_wr || pin_wr || rd_valid;
   assign off_req  = cmd_valid ? (!cmd_soft_rst && cmd_sense_off) : (cfg_wr && cfg_sense_off);
   assign cancel   = soft_rst || (tmr_busy && off_req);
   assign cmp_done = tmr_done && !cancel;
   assign dav_any  = |dav_q;

   // start gate and pending-data shutoff for the selected function
   always_comb begin
      cls      = fn_class(nfunc_q);
      gate_ok  = 1'b0;
      dis_cond = 1'b0;
      unique case (cls)
         GC_SCAN: begin gate_ok = pen_down; dis_cond = !host_q && dav_any;   end
         GC_PEN:  begin gate_ok = pen_down; dis_cond = pen_down && dav_any; end
         GC_ONCE: begin gate_ok = 1'b1;     dis_cond = dav_any;             end
         GC_LOOP: begin gate_ok = 1'b1;     dis_cond = 1'b0;                end
         default: begin gate_ok = 1'b0;     dis_cond = 1'b0;                end
      endcase
   end

   assign eval_dis = !any_ev && dis_cond;
   assign start    = !any_ev && sense_q && !dis_cond && gate_ok && !tmr_busy;

   seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cancel (cancel),
      .len    (conv_len),
      .busy   (tmr_busy),
      .done   (tmr_done)
   );

   seq_masks u_masks (
      .act_fn   (afunc_q),
      .rd_valid (rd_valid),
      .rd_addr  (rd_addr),
      .set_mask (set_mask),
      .clr_mask (clr_mask)
   );

   // per-bit next state of the data-ready register
   generate
      for (genvar b = 0; b < DAV_W; b++) begin : g_dav
         assign dav_d[b] = soft_rst ? 1'b0
                         : ((dav_q[b] && !clr_mask[b]) || (cmp_done && set_mask[b]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dav_q <= '0;
      else        dav_q <= dav_d;
   end

   // selection and mode registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q    <= 1'b0;
         host_q     <= 1'b0;
         nfunc_q    <= '0;
         nprec_q    <= 1'b0;
         pin_mode_q <= 2'd0;
      end else if (soft_rst) begin
         sense_q    <= 1'b0;
         nfunc_q    <= '0;
         nprec_q    <= 1'b0;
         pin_mode_q <= 2'd0;
      end else begin
         if (cmd_valid) begin
            sense_q <= !cmd_sense_off;
            nfunc_q <= cmd_func;
            nprec_q <= cmd_prec;
         end else if (cfg_wr) begin
            sense_q <= !cfg_sense_off;
            nprec_q <= cfg_prec;
         end else if (eval_dis) begin
            sense_q <= 1'b0;
         end
         if (cfg_wr)  host_q     <= cfg_host;
         if (pin_wr)  pin_mode_q <= pin_sel;
      end
   end

   // active-function and status flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avalid_q  <= 1'b0;
         afunc_q   <= '0;
         aprec_q   <= 1'b0;
         rstflag_q <= 1'b0;
         stflag_q  <= 1'b1;
         pnd_q     <= 1'b0;
      end else if (soft_rst) begin
         avalid_q  <= 1'b0;
         rstflag_q <= 1'b0;
         stflag_q  <= 1'b1;
         pnd_q     <= 1'b0;
      end else begin
         if (start) begin
            avalid_q <= 1'b1;
            afunc_q  <= nfunc_q;
            aprec_q  <= nprec_q;
            stflag_q <= !pnd_q;
         end else if (cmp_done || cancel) begin
            avalid_q <= 1'b0;
         end
         if (rd_valid) begin
            pnd_q <= rd_pnd;
            if (rd_addr == 4'd7) rstflag_q <= 1'b1;
         end
      end
   end

   seq_pin #(.REG_OUT(IRQ_REG)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (pin_mode_q),
      .pen     (pen_down),
      .dav_any (dav_any),
      .irq     (irq)
   );

   always_comb begin
      status_word = dav_q;
      status_word[STAT_BIT_RST] = dav_q[STAT_BIT_RST] | rstflag_q;
      status_word[STAT_BIT_PND] = dav_q[STAT_BIT_PND] | stflag_q;
   end

   assign busy      = tmr_busy;
   assign act_valid = avalid_q;
   assign act_func  = afunc_q;
   assign act_prec  = aprec_q;
   assign dav       = dav_q;
   assign sense_en  = sense_q;

   // R2: a conversion only begins out of an enabled cycle
   p_start_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(sense_q));
   // R3: completion posts every bit of the function's mask
   p_mask_posted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done |=> ((dav_q & $past(set_mask)) == $past(set_mask)));
   // R3: completion ends the active phase
   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_done |=> (!busy && !act_valid));
   // R6: a reserved code is never active
   p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (act_func < 4'd12));
   // R7: reading the first result drops its flag
   p_x_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_addr == 4'd0 && !cmp_done) |=> !dav_q[15]);
   // R8: a status read sets the reset-seen flag
   p_rst_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_addr == 4'd7 && !soft_rst) |=> status_word[7]);
   // R9: turning sensing off by command stops a conversion
   p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_soft_rst && cmd_sense_off) |=> !busy);
   // R11: soft reset empties the data-ready register
   p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dav_q == '0 && !sense_q));
endmodule

// File: tb/test_conv_seq.sv
module test_conv_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pen_down = 0, cmd_valid = 0, cmd_soft_rst = 0, cmd_prec = 0, cmd_sense_off = 0;
   logic [3:0] cmd_func = '0;
   logic cfg_wr = 0, cfg_host = 0, cfg_sense_off = 0, cfg_prec = 0;
   logic pin_wr = 0;
   logic [1:0] pin_sel = '0;
   logic [CW-1:0] conv_len = 4'd3;
   logic rd_valid = 0, rd_pnd = 0;
   logic [3:0] rd_addr = '0;
   logic busy, act_valid, act_prec, sense_en, irq;
   logic [3:0] act_func;
   logic [15:0] dav, status_word;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_seq #(.CNT_W(CW), .IRQ_REG(1'b1)) i_conv_seq (
      .clk(clk), .rst_n(rst_n), .pen_down(pen_down),
      .cmd_valid(cmd_valid), .cmd_soft_rst(cmd_soft_rst), .cmd_func(cmd_func),
      .cmd_prec(cmd_prec), .cmd_sense_off(cmd_sense_off),
      .cfg_wr(cfg_wr), .cfg_host(cfg_host), .cfg_sense_off(cfg_sense_off), .cfg_prec(cfg_prec),
      .pin_wr(pin_wr), .pin_sel(pin_sel), .conv_len(conv_len),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_pnd(rd_pnd),
      .busy(busy), .act_valid(act_valid), .act_func(act_func), .act_prec(act_prec),
      .dav(dav), .status_word(status_word), .sense_en(sense_en), .irq(irq)
   );

   function automatic logic [15:0] exp_mask(input int f);
      case (f)
         0: return 16'hF000;  1: return 16'hC000;  2: return 16'h8000;
         3: return 16'h4000;  4: return 16'h3000;  5: return 16'h0800;
         6: return 16'h0400;  7: return 16'h0200;  8: return 16'h0800;
         9: return 16'h0040; 10: return 16'h0020; 11: return 16'h0080;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic hard_reset();
      rst_n = 1'b0; pen_down = 0; cmd_valid = 0; cmd_soft_rst = 0; cfg_wr = 0;
      pin_wr = 0; rd_valid = 0; conv_len = 4'd3;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic do_cmd(input int f, input logic p, input logic off);
      cmd_valid = 1; cmd_func = 4'(f); cmd_prec = p; cmd_sense_off = off;
      step();
      cmd_valid = 0;
   endtask

   task automatic do_cfg(input logic host, input logic off, input logic p);
      cfg_wr = 1; cfg_host = host; cfg_sense_off = off; cfg_prec = p;
      step();
      cfg_wr = 0;
   endtask

   task automatic do_pin(input logic [1:0] m);
      pin_wr = 1; pin_sel = m;
      step();
      pin_wr = 0;
   endtask

   task automatic do_read(input int a, input logic pnd, output logic [15:0] seen);
      rd_valid = 1; rd_addr = 4'(a); rd_pnd = pnd;
      seen = status_word;
      step();
      rd_valid = 0;
   endtask

   task automatic run_done(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         step();
      end
   endtask

   task automatic t_reset();
      hard_reset();
      check("R1 busy", busy, 0);
      check("R1 act_valid", act_valid, 0);
      check("R1 sense_en", sense_en, 0);
      check("R1 irq", irq, 0);
      check("R1 dav", dav, 0);
      check("R1 status", status_word, 16'h0004);
   endtask

   task automatic t_start_and_length();
      int n;
      hard_reset();
      do_cmd(5, 1'b1, 1'b0);
      step();
      check("R2 busy after start", busy, 1);
      check("R2 act_func", act_func, 5);
      check("R2 act_prec", act_prec, 1);
      run_done(n);
      check("R3 length L=3", n, 4);
      check("R3 dav aux", dav, 16'h0800);
      check("R3 act_valid drop", act_valid, 0);
      step();
      check("R5 aux pending shuts sense", sense_en, 0);
      conv_len = 4'd0;
      do_cmd(6, 1'b0, 1'b0);
      step();
      check("R5 sense off again with pending data", sense_en, 0);
      check("R5 no start with pending data", busy, 0);
   endtask

   task automatic t_lengths();
      int n;
      hard_reset();
      conv_len = 4'd0;
      do_cmd(9, 1'b0, 1'b0);
      step();
      run_done(n);
      check("R3 length L=0", n, 1);
      hard_reset();
      conv_len = 4'd15;
      do_cmd(10, 1'b0, 1'b0);
      step();
      run_done(n);
      check("R3 length L=15", n, 16);
      check("R3 dav y test", dav, 16'h0020);
   endtask

   task automatic t_masks();
      int n;
      for (int f = 0; f < 12; f++) begin
         hard_reset();
         pen_down = 1;
         do_cmd(f, 1'b0, 1'b0);
         step();
         check($sformatf("R2 start code %0d", f), busy, 1);
         run_done(n);
         check($sformatf("R3 mask code %0d", f), dav, {16'h0, exp_mask(f)});
      end
      pen_down = 0;
   endtask

   task automatic t_pen_gate();
      hard_reset();
      do_cmd(2, 1'b0, 1'b0);
      repeat (4) step();
      check("R4 x waits for pen", busy, 0);
      check("R4 x pen up keeps sense", sense_en, 1);
      pen_down = 1;
      step();
      check("R4 x starts on pen", busy, 1);
      pen_down = 0;
      hard_reset();
      do_cmd(8, 1'b0, 1'b0);
      step();
      check("R4 aux scan pen up", busy, 1);
   endtask

   task automatic t_pending_rules();
      int n;
      logic [15:0] s;
      hard_reset();
      do_cmd(8, 1'b0, 1'b0);
      step();
      run_done(n);
      check("R5 aux scan keeps sense", sense_en, 1);
      do_cmd(2, 1'b0, 1'b0);
      repeat (3) step();
      check("R5 x pen up no shutoff", sense_en, 1);
      check("R5 x pen up idle", busy, 0);
      pen_down = 1;
      step();
      check("R5 x pen down shutoff", sense_en, 0);
      check("R5 x pen down no start", busy, 0);
      pen_down = 0;
      hard_reset();
      do_cmd(5, 1'b0, 1'b0);
      step();
      run_done(n);
      step();
      do_cmd(1, 1'b0, 1'b0);
      check("R5 xy enabled by command", sense_en, 1);
      step();
      check("R5 xy host off shutoff", sense_en, 0);
      do_cfg(1'b1, 1'b0, 1'b0);
      repeat (3) step();
      check("R5 xy host on keeps sense", sense_en, 1);
      pen_down = 1;
      step();
      check("R4 xy host on starts with pen", busy, 1);
      pen_down = 0;
      do_read(7, 1'b0, s);
   endtask

   task automatic t_reserved();
      hard_reset();
      pen_down = 1;
      for (int f = 12; f < 16; f++) begin
         do_cmd(f, 1'b0, 1'b0);
         repeat (3) step();
         check($sformatf("R6 code %0d idle", f), busy, 0);
         check($sformatf("R6 code %0d inactive", f), act_valid, 0);
      end
      pen_down = 0;
   endtask

   task automatic t_reads();
      int n;
      logic [15:0] s;
      hard_reset();
      do_cfg(1'b1, 1'b0, 1'b0);
      pen_down = 1;
      step();
      run_done(n);
      pen_down = 0;
      check("R3 xyz host mask", dav, 16'hF000);
      step();
      check("R4 xyz stops pen up", busy, 0);
      do_read(6, 1'b0, s);
      check("R7 temp2 clears two bits", dav, 16'hD000);
      do_read(3, 1'b0, s);
      check("R7 z2 clear", dav, 16'hC000);
      do_read(12, 1'b0, s);
      check("R7 high address no effect", dav, 16'hC000);
      do_read(0, 1'b0, s);
      check("R7 x clear", dav, 16'h4000);
      do_read(1, 1'b0, s);
      check("R7 y clear", dav, 16'h0000);
   endtask

   task automatic t_status();
      int n;
      logic [15:0] s;
      hard_reset();
      do_read(7, 1'b1, s);
      check("R8 first status", s, 16'h0004);
      check("R8 reset seen set", status_word, 16'h0084);
      do_cmd(9, 1'b0, 1'b0);
      step();
      check("R8 flag inverse of pnd", status_word, 16'h0080);
      run_done(n);
      check("R8 test bit in status", status_word, 16'h00C0);
      do_read(7, 1'b0, s);
      check("R8 status read value", s, 16'h00C0);
      check("R7 status read clears tests", status_word, 16'h0080);
   endtask

   task automatic t_cancel();
      hard_reset();
      do_cmd(8, 1'b0, 1'b0);
      step(); step();
      check("R9 running", busy, 1);
      do_cmd(8, 1'b0, 1'b1);
      check("R9 cmd cancel busy", busy, 0);
      check("R9 cmd cancel sense", sense_en, 0);
      repeat (5) step();
      check("R9 cmd cancel no post", dav, 0);
      do_cmd(8, 1'b0, 1'b0);
      step();
      do_cfg(1'b0, 1'b1, 1'b0);
      check("R9 cfg cancel busy", busy, 0);
      repeat (5) step();
      check("R9 cfg cancel no post", dav, 0);
   endtask

   task automatic t_irq();
      int n;
      logic [15:0] s;
      hard_reset();
      do_cmd(5, 1'b0, 1'b0);
      step();
      run_done(n);
      check("R10 mode0 registered lag", irq, 0);
      step();
      check("R10 mode0 pen up data", irq, 1);
      pen_down = 1;
      step();
      check("R10 mode0 pen down", irq, 0);
      do_pin(2'd2);
      step();
      check("R10 mode2 pen down", irq, 0);
      pen_down = 0;
      step();
      check("R10 mode2 pen up", irq, 1);
      do_pin(2'd1);
      step();
      check("R10 mode1 data pending", irq, 0);
      do_read(4, 1'b0, s);
      step();
      check("R10 mode1 no data", irq, 1);
      do_pin(2'd3);
      step();
      check("R10 mode3 no data", irq, 1);
   endtask

   task automatic t_soft_reset();
      int n;
      logic [15:0] s;
      hard_reset();
      do_cmd(5, 1'b1, 1'b0);
      step();
      run_done(n);
      do_read(7, 1'b1, s);
      do_pin(2'd2);
      step();
      check("R11 pre irq mode2", irq, 1);
      cmd_valid = 1; cmd_soft_rst = 1;
      step();
      cmd_valid = 0; cmd_soft_rst = 0;
      check("R11 dav", dav, 0);
      check("R11 status", status_word, 16'h0004);
      check("R11 sense", sense_en, 0);
      step();
      check("R11 pin mode back to 0", irq, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_start_and_length();
      t_lengths();
      t_masks();
      t_pen_gate();
      t_pending_rules();
      t_reserved();
      t_reads();
      t_status();
      t_cancel();
      t_irq();
      t_soft_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule